// File: doc/BRIEF.md
# SDRAM Request Splitter

This block sits between an application request port and a per-bank SDRAM controller. The application offers one transfer at a time: a start address and a length, both counted in 32-bit application words, plus a direction bit and a wrap flag. The splitter first scales the address and length into memory words for the configured memory data width. It then cuts the transfer into pieces so that no piece runs past the end of a page. The page size is the number of columns picked by a runtime column-width setting. For every piece it decodes the bank, row and column from the memory-word address. It marks the first and last pieces and presents each piece on a valid/ready output.

A wrap request bypasses splitting. It is issued as one piece of length 4 that starts at the decoded column.

Both sides are valid/ready:
- Request side: the application holds `in_valid` and every request field steady until it sees `in_ready`. `in_ready` is asserted only in the cycle where the final piece is accepted downstream, so it acknowledges the whole transfer.
- Piece side: while `out_valid` is high and `out_ready` is low, every piece field is held unchanged.
- Configuration: the column width, memory width and bank-count settings are sampled when a request is loaded. They are held for that request.

Top module: `sdram_req_splitter`

## Requirements
- R1: During and right after reset, `out_valid` and `in_ready` are 0 and `idle` is 1.
- R2: The address and length are multiplied by 1, 2 or 4 for a memory width code of 00 (32-bit), 01 (16-bit) or 1x (8-bit) before any decode or split. Wrap requests skip the length scaling.
- R3: The column width code 00/01/10/11 selects 8/9/10/11 column bits. `out_col` is the low column bits of the scaled address, zero-extended to 12 bits.
- R4: With `cfg_four_bank`=1, `out_bank` is the two address bits above the column and `out_row` is the next 12 bits. With `cfg_four_bank`=0, `out_bank[1]` is 0, `out_bank[0]` is the one bit above the column and `out_row` is the next 12 bits.
- R5: A non-wrap piece length is the smaller of the remaining length and the columns left before the page end. Each following piece starts at the previous start plus the previous length.
- R6: `out_first` is 1 only on the first piece of a request. `out_last` is 1 only on its final piece.
- R7: A wrap request gives exactly one piece with length 4, first=1, last=1 and `out_wrap`=1, whatever `in_len` is.
- R8: `out_write` is 1 when `in_wr_n` is 0 (write) and 0 when it is 1 (read).
- R9: While `out_valid` is 1 and `out_ready` is 0, every piece field stays unchanged into the next cycle.
- R10: `in_ready` is 1 only in the cycle where a piece with `out_last`=1 is accepted. It is 0 in every other cycle.
- R11: When idle, a request seen on `in_valid` makes `out_valid` rise after one clock edge. `out_valid` stays high until the last piece is accepted, and `idle` is 1 in the cycle after that acceptance.
- R12: A non-wrap request of length 0 gives one piece of length 0, marked both first and last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_col_sel | input | 2 | Column width code: 00=8, 01=9, 10=10, 11=11 bits |
| cfg_mem_width | input | 2 | Memory width: 00=32-bit, 01=16-bit, 1x=8-bit |
| cfg_four_bank | input | 1 | 1 = four-bank device, 0 = two-bank device |
| in_valid | input | 1 | Application request valid |
| in_ready | output | 1 | Request fully issued (acknowledge) |
| in_addr | input | AW | Start address in application words |
| in_len | input | LEN_W | Length in application words |
| in_wrap | input | 1 | Wrap request (fixed length 4, no split) |
| in_wr_n | input | 1 | 0 = write, 1 = read |
| out_valid | output | 1 | Piece valid |
| out_ready | input | 1 | Bank controller accepts piece |
| out_bank | output | 2 | Bank of the piece |
| out_row | output | 12 | Row address of the piece |
| out_col | output | 12 | Column address of the piece |
| out_len | output | LEN_W+2 | Piece length in memory words |
| out_first | output | 1 | First piece of the request |
| out_last | output | 1 | Final piece of the request |
| out_wrap | output | 1 | Piece belongs to a wrap request |
| out_write | output | 1 | Piece is a write |
| idle | output | 1 | No request in progress |

## Verification
The bench builds the block with its default parameters: a 24-bit application address and 9-bit length. This gives scaled lengths of up to 2044 memory words. With 8 column bits, one request can therefore span nine pages and exercise many consecutive splits. With 11 column bits it reaches the full 2048-column page, where a length of 1 near the page end shows the one-column remainder. The scaled address is 26 bits wide, so random addresses also reach high rows and the row truncation used by both bank layouts.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 12;
  localparam int COL_W  = 12;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [COL_W-1:0]  cols_left;
  } loc_t;

  function automatic int col_bits(input logic [1:0] sel);
    return 8 + int'(sel);
  endfunction

  function automatic int width_shift(input logic [1:0] w);
    if (w[1]) return 2;
    else if (w[0]) return 1;
    else return 0;
  endfunction
endpackage

// File: rtl/srs_scaler.sv
module srs_scaler #(
  parameter int AW    = 24,
  parameter int LEN_W = 9,
  localparam int MW_W  = AW + 2,
  localparam int OLEN_W = LEN_W + 2
) (
  input  logic [1:0]        mem_width,
  input  logic [AW-1:0]     addr,
  input  logic [LEN_W-1:0]  len,
  output logic [MW_W-1:0]   mem_addr,
  output logic [OLEN_W-1:0] mem_len
);
  import srs_pkg::*;

  always_comb begin
    mem_addr = MW_W'(addr) << width_shift(mem_width);
    mem_len  = OLEN_W'(len) << width_shift(mem_width);
  end
endmodule

// File: rtl/srs_decode.sv
module srs_decode #(
  parameter int MW_W = 26
) (
  input  logic [MW_W-1:0] mem_addr,
  input  logic [1:0]      col_sel,
  input  logic            four_bank,
  output srs_pkg::loc_t   loc
);
  import srs_pkg::*;

  int cb;
  int nb;
  logic [MW_W-1:0] mask;

  always_comb begin
    cb   = col_bits(col_sel);
    nb   = four_bank ? 2 : 1;
    mask = (MW_W'(1) << cb) - MW_W'(1);
    loc.col  = COL_W'(mem_addr & mask);
    loc.bank = BANK_W'(mem_addr >> cb) & (four_bank ? 2'b11 : 2'b01);
    loc.row  = ROW_W'(mem_addr >> (cb + nb));
    loc.cols_left = COL_W'((13'd1 << cb) - 13'(loc.col));
  end
endmodule

// File: rtl/srs_sizer.sv
module srs_sizer #(
  parameter int OLEN_W = 11,
  localparam int CMP_W = (OLEN_W > srs_pkg::COL_W) ? OLEN_W : srs_pkg::COL_W
) (
  input  logic [OLEN_W-1:0]          remaining,
  input  logic [srs_pkg::COL_W-1:0]  cols_left,
  input  logic                       wrap,
  output logic [OLEN_W-1:0]          piece_len,
  output logic                       piece_last
);
  logic [CMP_W-1:0] rem_x;
  logic [CMP_W-1:0] left_x;
  logic             fits;

  always_comb begin
    rem_x  = CMP_W'(remaining);
    left_x = CMP_W'(cols_left);
    fits   = rem_x <= left_x;
    if (wrap) begin
      piece_len  = remaining;
      piece_last = 1'b1;
    end else begin
      piece_len  = fits ? remaining : OLEN_W'(cols_left);
      piece_last = fits;
    end
  end
endmodule

// File: rtl/sdram_req_splitter.sv
module sdram_req_splitter #(
  parameter int AW    = 24,
  parameter int LEN_W = 9,
  parameter int WRAP_LEN = 4,
  localparam int MW_W   = AW + 2,
  localparam int OLEN_W = LEN_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_col_sel,
  input  logic [1:0]        cfg_mem_width,
  input  logic              cfg_four_bank,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [AW-1:0]     in_addr,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_wrap,
  input  logic              in_wr_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_bank,
  output logic [11:0]       out_row,
  output logic [11:0]       out_col,
  output logic [OLEN_W-1:0] out_len,
  output logic              out_first,
  output logic              out_last,
  output logic              out_wrap,
  output logic              out_write,
  output logic              idle
);
  import srs_pkg::*;

  logic              busy_q;
  logic [MW_W-1:0]   cur_q;
  logic [OLEN_W-1:0] rem_q;
  logic              first_q, wrap_q, write_q, fb_q;
  logic [1:0]        col_sel_q;

  logic [MW_W-1:0]   load_addr;
  logic [OLEN_W-1:0] load_len;
  loc_t              loc;
  logic [OLEN_W-1:0] piece_len;
  logic              piece_last;
  logic              load, fire;

  srs_scaler #(.AW(AW), .LEN_W(LEN_W)) u_scaler (
    .mem_width (cfg_mem_width),
    .addr      (in_addr),
    .len       (in_len),
    .mem_addr  (load_addr),
    .mem_len   (load_len)
  );

  srs_decode #(.MW_W(MW_W)) u_decode (
    .mem_addr  (cur_q),
    .col_sel   (col_sel_q),
    .four_bank (fb_q),
    .loc       (loc)
  );

  srs_sizer #(.OLEN_W(OLEN_W)) u_sizer (
    .remaining  (rem_q),
    .cols_left  (loc.cols_left),
    .wrap       (wrap_q),
    .piece_len  (piece_len),
    .piece_last (piece_last)
  );

  assign load = !busy_q && in_valid;
  assign fire = busy_q && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cur_q     <= '0;
      rem_q     <= '0;
      first_q   <= 1'b0;
      wrap_q    <= 1'b0;
      write_q   <= 1'b0;
      fb_q      <= 1'b0;
      col_sel_q <= 2'b00;
    end else if (load) begin
      busy_q    <= 1'b1;
      cur_q     <= load_addr;
      rem_q     <= in_wrap ? OLEN_W'(WRAP_LEN) : load_len;
      first_q   <= 1'b1;
      wrap_q    <= in_wrap;
      write_q   <= !in_wr_n;
      fb_q      <= cfg_four_bank;
      col_sel_q <= cfg_col_sel;
    end else if (fire) begin
      if (piece_last) begin
        busy_q <= 1'b0;
      end else begin
        cur_q   <= cur_q + MW_W'(piece_len);
        rem_q   <= rem_q - piece_len;
        first_q <= 1'b0;
      end
    end
  end

  assign out_valid = busy_q;
  assign out_bank  = loc.bank;
  assign out_row   = loc.row;
  assign out_col   = loc.col;
  assign out_len   = piece_len;
  assign out_first = first_q;
  assign out_last  = piece_last;
  assign out_wrap  = wrap_q;
  assign out_write = write_q;
  assign in_ready  = fire && piece_last;
  assign idle      = !busy_q;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bank) && $stable(out_row)
      && $stable(out_col) && $stable(out_len) && $stable(out_first)
      && $stable(out_last) && $stable(out_wrap) && $stable(out_write));

  // R10
  ack_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> out_valid && out_ready && out_last);

  // R6
  first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && !out_first);

  // R5
  page_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_wrap |-> (14'(out_col) + 14'(out_len)) <= (14'd1 << col_bits(col_sel_q)));

  // R7
  wrap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wrap |-> out_first && out_last && out_len == OLEN_W'(WRAP_LEN));

  // R11
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> idle && !out_valid);
endmodule

// File: tb/sdram_req_splitter_tb.sv
module sdram_req_splitter_tb;
  localparam int AW = 24;
  localparam int LW = 9;
  localparam int MW = AW + 2;
  localparam int OLW = LW + 2;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_col_sel, cfg_mem_width;
  logic cfg_four_bank;
  logic in_valid, in_ready, in_wrap, in_wr_n;
  logic [AW-1:0] in_addr;
  logic [LW-1:0] in_len;
  logic out_valid, out_ready, out_first, out_last, out_wrap, out_write, idle;
  logic [1:0] out_bank;
  logic [11:0] out_row, out_col;
  logic [OLW-1:0] out_len;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sdram_req_splitter #(.AW(AW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_col_sel(cfg_col_sel), .cfg_mem_width(cfg_mem_width),
    .cfg_four_bank(cfg_four_bank), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_len(in_len), .in_wrap(in_wrap), .in_wr_n(in_wr_n),
    .out_valid(out_valid), .out_ready(out_ready), .out_bank(out_bank), .out_row(out_row),
    .out_col(out_col), .out_len(out_len), .out_first(out_first), .out_last(out_last),
    .out_wrap(out_wrap), .out_write(out_write), .idle(idle)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned page_cols(input logic [1:0] s);
    case (s)
      2'b00: return 256;
      2'b01: return 512;
      2'b10: return 1024;
      default: return 2048;
    endcase
  endfunction

  function automatic longint unsigned scale(input logic [1:0] w);
    if (w == 2'b00) return 1;
    if (w == 2'b01) return 2;
    return 4;
  endfunction

  task automatic run_req(input logic [AW-1:0] a, input logic [LW-1:0] l,
                         input bit w, input bit wrn, input int pct);
    longint unsigned e_mw, e_rem, pc, nbk, left, plen, ecol, ebank, erow;
    bit e_first, e_last, fin, stalled;
    logic [11:0] h_col, h_row;
    logic [1:0] h_bank;
    logic [OLW-1:0] h_len;
    int guard;
    pc  = page_cols(cfg_col_sel);
    nbk = cfg_four_bank ? 4 : 2;
    e_mw = (longint'(a) * scale(cfg_mem_width)) % (64'd1 << MW);
    e_rem = w ? 4 : longint'(l) * scale(cfg_mem_width);
    e_first = 1'b1;
    @(negedge clk);
    in_addr = a; in_len = l; in_wrap = w; in_wr_n = wrn; in_valid = 1'b1; out_ready = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R11 no piece before load edge", out_valid, 0);
    fin = 1'b0; stalled = 1'b0; guard = 0;
    h_col = '0; h_row = '0; h_bank = '0; h_len = '0;
    while (!fin && guard < 5000) begin
      guard++;
      @(negedge clk);
      out_ready = ($urandom_range(99) < pct);
      #1;
      chk(out_valid == 1'b1, "R11 valid while busy", out_valid, 1);
      if (stalled) begin
        chk(out_col == h_col && out_row == h_row && out_bank == h_bank && out_len == h_len,
            "R9 fields held under stall", out_col, h_col);
      end
      ecol  = e_mw % pc;
      left  = pc - ecol;
      ebank = (e_mw / pc) % nbk;
      erow  = (e_mw / (pc * nbk)) % 4096;
      if (w) begin plen = 4; e_last = 1'b1; end
      else if (e_rem <= left) begin plen = e_rem; e_last = 1'b1; end
      else begin plen = left; e_last = 1'b0; end
      chk(out_col == ecol, "R2 R3 column", out_col, ecol);
      chk(out_bank == ebank, "R4 bank", out_bank, ebank);
      chk(out_row == erow, "R4 row", out_row, erow);
      chk(out_len == plen, "R5 piece length", out_len, plen);
      chk(out_first == e_first, "R6 first flag", out_first, e_first);
      chk(out_last == e_last, "R6 last flag", out_last, e_last);
      chk(out_wrap == w, "R7 wrap flag", out_wrap, w);
      chk(out_write == !wrn, "R8 write flag", out_write, !wrn);
      if (out_ready) begin
        chk(in_ready == e_last, "R10 ack on final accept", in_ready, e_last);
        stalled = 1'b0;
        if (e_last) fin = 1'b1;
        else begin
          e_mw = (e_mw + plen) % (64'd1 << MW);
          e_rem = e_rem - plen;
          e_first = 1'b0;
        end
      end else begin
        chk(in_ready == 1'b0, "R10 no ack while stalled", in_ready, 0);
        stalled = 1'b1;
        h_col = out_col; h_row = out_row; h_bank = out_bank; h_len = out_len;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk(idle == 1'b1 && out_valid == 1'b0, "R11 idle after last piece", idle, 1);
  endtask

  task automatic set_cfg(input logic [1:0] cs, input logic [1:0] mw, input bit fb);
    @(negedge clk);
    cfg_col_sel = cs; cfg_mem_width = mw; cfg_four_bank = fb;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_addr = '0; in_len = '0;
    in_wrap = 1'b0; in_wr_n = 1'b1; cfg_col_sel = 2'b00; cfg_mem_width = 2'b00; cfg_four_bank = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b0, "R1 reset in_ready", in_ready, 0);
    chk(idle == 1'b1, "R1 reset idle", idle, 1);
    rst_n = 1'b1;
    #1;
    chk(idle == 1'b1 && out_valid == 1'b0, "R1 after reset release", idle, 1);

    // R2 R5: 16-bit memory, page split close to the page end
    set_cfg(2'b00, 2'b01, 1'b1);
    run_req(24'h00007E, 9'd5, 1'b0, 1'b0, 100);
    // R2: 8-bit memory with 11 column bits, long transfer
    set_cfg(2'b11, 2'b10, 1'b1);
    run_req(24'h0001FF, 9'd511, 1'b0, 1'b1, 60);
    // R7: wrap ignores length
    set_cfg(2'b01, 2'b00, 1'b1);
    run_req(24'h0001FE, 9'd200, 1'b1, 1'b0, 50);
    // R12: zero length
    run_req(24'h123456, 9'd0, 1'b0, 1'b1, 100);
    // R4: two-bank layout
    set_cfg(2'b10, 2'b00, 1'b0);
    run_req(24'hABCDEF, 9'd300, 1'b0, 1'b0, 40);
    // R9: heavy stall
    set_cfg(2'b00, 2'b10, 1'b1);
    run_req(24'hFFFFF0, 9'd100, 1'b0, 1'b1, 20);

    for (int i = 0; i < 200; i++) begin
      logic [LW-1:0] l;
      set_cfg(2'($urandom), 2'($urandom), 1'($urandom));
      l = ($urandom_range(3) == 0) ? LW'($urandom) : LW'($urandom_range(40));
      run_req(AW'($urandom), l, ($urandom_range(7) == 0), 1'($urandom), 30 + $urandom_range(70));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule